// File: doc/BRIEF.md
# NAND page Hamming ECC engine

This engine sits beside the data path between a host and a NAND flash device. It sees every data word that crosses that path. During a page write it builds one Hamming-style code for the whole page. The code is two 16-bit halves. The first half is the XOR of the bit addresses of every set data bit. The second half is the same XOR taken over the inverted bit addresses. The host reads both halves and stores them in the spare area as four code bytes.

During a page read the stored four code bytes must follow the page data directly. The engine captures them and XORs them with the parity it recomputed. From the two resulting syndrome halves it decides one of four outcomes: no error, a correctable single-bit data error, a single-bit error inside the code itself, or an uncorrectable multiple-bit error. For a data error, the location of the bad bit is left in the parity register as a word offset and a bit offset, and the host fixes its own buffer. A page that is still erased (all ones, code included) reports a multiple error at the all-ones location, so software can recognise it.

A clear input discards everything gathered so far, for example address cycles that were seen before the data phase. The next strobe after a finished check starts a new page by itself.

Top module: `nand_ecc_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, both parity registers and all three error flags read zero after that edge.
- R2: `page_sel` values 0, 1, 2 and 3 select pages of 528, 1056, 2112 and 4224 bytes. The page is that many words in byte mode and half that many in 16-bit mode. Only that many strobes are taken as page data before code capture begins.
- R3: After the last data word, `par_reg` holds the XOR of {word_index[11:0], bit_index[3:0]} over every set data bit, and `npar_reg` holds the XOR of the bitwise inverse of that address. Both stay unchanged while the code words are strobed in.
- R4: Code words are taken in this order. In byte mode, four strobes on bits [7:0] carry `par_reg` low byte, `par_reg` high byte, `npar_reg` low byte, then `npar_reg` high byte. In 16-bit mode, two strobes carry `par_reg`, then `npar_reg`.
- R5: On the second clock edge after the last code word is sampled, the parity registers hold the syndrome: computed parity XOR captured code, for each half. The flags are set from that syndrome. A zero syndrome clears all three flags.
- R6: If the two syndrome halves are bitwise complements (a single data-bit error), only `err_recov` is set, and `par_reg` gives the location: bits [15:4] are the word offset and bits [3:0] are the bit offset.
- R7: If exactly one bit is set across both syndrome halves (an error in a code byte), `err_recov` and `err_in_code` are set and `err_multi` is clear.
- R8: Any other non-zero syndrome (for example two flipped data bits) sets `err_recov` and `err_multi` and leaves `err_in_code` clear.
- R9: An erased page, with all data and all four code bytes at ones, reports `err_recov` and `err_multi` with `par_reg` = 16'hFFFF.
- R10: A high `ecc_clr` at a clock edge zeroes both parity registers and the flags, and restarts the page at word 0. Strobes seen before the clear have no effect on the next page's parity.
- R11: A strobe arriving after a check has completed starts a new page. It clears the flags and is taken as word 0 of that page.
- R12: In 16-bit mode the word offset counts 16-bit words and the bit offset covers bits 0 to 15. In byte mode only `dat_word[7:0]` is used and the bit offset covers bits 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ecc_clr | input | 1 | Discard accumulated parity and flags, restart at word 0 |
| page_sel | input | 2 | Page size select (528 bytes shifted left by this value) |
| wide_bus | input | 1 | 1: 16-bit data words, 0: byte words on bits [7:0] |
| dat_stb | input | 1 | One data or code word is present this cycle |
| dat_word | input | 16 | Data or code word |
| par_reg | output | 16 | Parity half, or syndrome / error location after a check |
| npar_reg | output | 16 | Complemented-parity half, or its syndrome after a check |
| err_recov | output | 1 | Error found (set for every non-zero syndrome) |
| err_in_code | output | 1 | The single-bit error lies in the code bytes |
| err_multi | output | 1 | Multiple-bit error, not correctable |

## Verification
The bench flips single data bits at the first bit of the first word and at the top bit of the last word, in both bus widths and at several page sizes. An engine that miscounts the page length or mixes up the code byte order captures the wrong code, so it reports a multiple error where a single one was planted. It also flips single code bits and two data bits at once, and feeds an erased page. A classifier with its tests in the wrong order would call a code-bit error or an erased page a data error, or would report a location other than all ones. Finally it sends junk words before a clear and begins a page with no clear after a flagged check. An engine that keeps stale parity or stale flags then fails the parity or flag checks.

// File: rtl/nand_ecc_pkg.sv
// Shared widths and types for the NAND page ECC engine.
// Assumes a fixed 16-bit location: 12-bit word offset, 4-bit bit offset.
package nand_ecc_pkg;
    localparam int BIT_IDX_W  = 4;
    localparam int WORD_IDX_W = 12;
    localparam int LOC_W      = WORD_IDX_W + BIT_IDX_W;
    localparam int DATA_W     = 16;

    typedef enum logic [1:0] {
        PH_DATA  = 2'd0,
        PH_CODE  = 2'd1,
        PH_CHECK = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

    typedef struct packed {
        logic recov;
        logic in_code;
        logic multi;
    } ecc_status_t;
endpackage

// File: rtl/nand_ecc_seq.sv
// Page sequencer: counts data words up to the selected page length, then the
// code words, then spends one cycle on the check.
// Assumes the page size and bus width are stable during a page, and that no
// strobe arrives in the single check cycle.
module nand_ecc_seq
    import nand_ecc_pkg::*;
#(
    parameter int PAGE_BASE = 528,
    parameter int SEL_W     = 2,
    parameter int CNT_W     = 13
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  stb,
    input  logic [SEL_W-1:0]      page_sel,
    input  logic                  wide,
    output phase_e                phase,
    output logic [WORD_IDX_W-1:0] word_idx,
    output logic                  acc_en,
    output logic                  restart,
    output logic                  code_en,
    output logic [1:0]            code_slot,
    output logic                  check_now
);
    localparam logic [CNT_W:0] BASE_EXT = (CNT_W+1)'(PAGE_BASE);

    phase_e            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W:0]    page_bytes;
    logic [CNT_W:0]    page_words;
    logic [CNT_W:0]    last_word;
    logic [CNT_W-1:0]  code_last;

    // Derive the page length in words and the last code slot from the mode
    always_comb begin
        page_bytes = BASE_EXT << page_sel;
        page_words = wide ? (page_bytes >> 1) : page_bytes;
        last_word  = page_words - (CNT_W+1)'(1);
        code_last  = wide ? CNT_W'(1) : CNT_W'(3);
    end

    // Advance the phase and the word counter on each accepted strobe
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase_q <= PH_DATA;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_DATA: if (stb) begin
                    if ({1'b0, cnt_q} == last_word) begin
                        phase_q <= PH_CODE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                PH_CODE: if (stb) begin
                    if (cnt_q == code_last) begin
                        phase_q <= PH_CHECK;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                PH_CHECK: phase_q <= PH_DONE;
                default: if (stb) begin
                    phase_q <= PH_DATA;
                    cnt_q   <= CNT_W'(1);
                end
            endcase
        end
    end

    // Decode per-strobe actions for the datapath
    always_comb begin
        phase     = phase_q;
        acc_en    = stb && !clr && (phase_q == PH_DATA || phase_q == PH_DONE);
        restart   = stb && !clr && (phase_q == PH_DONE);
        code_en   = stb && !clr && (phase_q == PH_CODE);
        code_slot = cnt_q[1:0];
        word_idx  = (phase_q == PH_DONE) ? '0 : cnt_q[WORD_IDX_W-1:0];
        check_now = !clr && (phase_q == PH_CHECK);
    end
endmodule

// File: rtl/nand_ecc_acc.sv
// Parity accumulator: folds each data word's bit addresses into the parity
// half and its inverse into the complemented half; loads the syndrome after
// a check. Assumes byte mode drives data on the low half of the word.
module nand_ecc_acc
    import nand_ecc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  restart,
    input  logic                  acc_en,
    input  logic                  wide,
    input  logic [WORD_IDX_W-1:0] idx,
    input  logic [DATA_W-1:0]     din,
    input  logic                  load_syn,
    input  logic [LOC_W-1:0]      syn_p,
    input  logic [LOC_W-1:0]      syn_n,
    output logic [LOC_W-1:0]      par_q,
    output logic [LOC_W-1:0]      npar_q
);
    localparam int NARROW = DATA_W / 2;

    logic [DATA_W-1:0]    lane;
    logic [BIT_IDX_W-1:0] bit_x;
    logic                 w_par;
    logic [LOC_W-1:0]     add_p;
    logic [LOC_W-1:0]     add_n;
    logic [LOC_W-1:0]     base_p;
    logic [LOC_W-1:0]     base_n;

    // Mask the upper lanes when the bus is byte wide
    for (genvar g = 0; g < DATA_W; g++) begin : g_lane
        if (g < NARROW) begin : g_lo
            assign lane[g] = din[g];
        end else begin : g_hi
            assign lane[g] = din[g] & wide;
        end
    end

    // Build this word's contribution to both parity halves
    always_comb begin
        bit_x = '0;
        for (int j = 0; j < DATA_W; j++) begin
            if (lane[j]) bit_x = bit_x ^ BIT_IDX_W'(j);
        end
        w_par  = ^lane;
        add_p  = {idx & {WORD_IDX_W{w_par}}, bit_x};
        add_n  = add_p ^ {LOC_W{w_par}};
        base_p = restart ? '0 : par_q;
        base_n = restart ? '0 : npar_q;
    end

    // Accumulate, restart or load the syndrome
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            par_q  <= '0;
            npar_q <= '0;
        end else if (load_syn) begin
            par_q  <= syn_p;
            npar_q <= syn_n;
        end else if (acc_en) begin
            par_q  <= base_p ^ add_p;
            npar_q <= base_n ^ add_n;
        end
    end
endmodule

// File: rtl/nand_ecc_syn.sv
// Code capture and syndrome classifier: gathers the stored code words, forms
// the syndrome against the recomputed parity and registers the status flags.
// Assumes code words come in the fixed order parity low/high, then
// complemented parity low/high (byte mode) or parity, complemented parity.
module nand_ecc_syn
    import nand_ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              restart,
    input  logic              code_en,
    input  logic [1:0]        slot,
    input  logic              wide,
    input  logic [DATA_W-1:0] din,
    input  logic              check_now,
    input  logic [LOC_W-1:0]  par_q,
    input  logic [LOC_W-1:0]  npar_q,
    output logic [LOC_W-1:0]  syn_p,
    output logic [LOC_W-1:0]  syn_n,
    output ecc_status_t       status_q
);
    logic [LOC_W-1:0] code_p;
    logic [LOC_W-1:0] code_n;
    ecc_status_t      status_d;
    logic             syn_zero;
    logic             syn_single;
    logic             syn_compl;

    // Capture stored code words into the two halves
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            code_p <= '0;
            code_n <= '0;
        end else if (code_en) begin
            if (wide) begin
                if (!slot[0]) code_p <= din;
                else          code_n <= din;
            end else begin
                case (slot)
                    2'd0:    code_p[7:0]  <= din[7:0];
                    2'd1:    code_p[15:8] <= din[7:0];
                    2'd2:    code_n[7:0]  <= din[7:0];
                    default: code_n[15:8] <= din[7:0];
                endcase
            end
        end
    end

    // Form the syndrome and classify it
    always_comb begin
        syn_p      = par_q ^ code_p;
        syn_n      = npar_q ^ code_n;
        syn_zero   = ({syn_p, syn_n} == '0);
        syn_single = ($countones({syn_p, syn_n}) == 1);
        syn_compl  = ((syn_p ^ syn_n) == '1);
        status_d   = '0;
        if (!syn_zero) begin
            status_d.recov = 1'b1;
            if (syn_single)      status_d.in_code = 1'b1;
            else if (!syn_compl) status_d.multi   = 1'b1;
        end
    end

    // Register the flags at the check, clear them on a new page
    always_ff @(posedge clk) begin
        if (!rst_n || clr || restart) status_q <= '0;
        else if (check_now)           status_q <= status_d;
    end
endmodule

// File: rtl/nand_ecc_engine.sv
// Top of the NAND page ECC engine: joins the sequencer, the parity
// accumulator and the syndrome classifier. Assumes strobed words are already
// decoded from the bus. In byte mode only the three smallest sizes keep word
// offsets unique in the 12-bit field.
module nand_ecc_engine
    import nand_ecc_pkg::*;
#(
    parameter int PAGE_BASE  = 528,
    parameter int SIZE_MODES = 4,
    localparam int SEL_W = (SIZE_MODES > 1) ? $clog2(SIZE_MODES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_clr,
    input  logic [SEL_W-1:0]  page_sel,
    input  logic              wide_bus,
    input  logic              dat_stb,
    input  logic [DATA_W-1:0] dat_word,
    output logic [LOC_W-1:0]  par_reg,
    output logic [LOC_W-1:0]  npar_reg,
    output logic              err_recov,
    output logic              err_in_code,
    output logic              err_multi
);
    localparam int CNT_W = $clog2((PAGE_BASE << (SIZE_MODES - 1)) + 1);

    phase_e                phase_w;
    logic [WORD_IDX_W-1:0] idx_w;
    logic                  acc_w;
    logic                  restart_w;
    logic                  code_w;
    logic [1:0]            slot_w;
    logic                  check_w;
    logic [LOC_W-1:0]      syn_p_w;
    logic [LOC_W-1:0]      syn_n_w;
    ecc_status_t           status_w;

    nand_ecc_seq #(
        .PAGE_BASE (PAGE_BASE),
        .SEL_W     (SEL_W),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ecc_clr),
        .stb       (dat_stb),
        .page_sel  (page_sel),
        .wide      (wide_bus),
        .phase     (phase_w),
        .word_idx  (idx_w),
        .acc_en    (acc_w),
        .restart   (restart_w),
        .code_en   (code_w),
        .code_slot (slot_w),
        .check_now (check_w)
    );

    nand_ecc_acc u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ecc_clr),
        .restart  (restart_w),
        .acc_en   (acc_w),
        .wide     (wide_bus),
        .idx      (idx_w),
        .din      (dat_word),
        .load_syn (check_w),
        .syn_p    (syn_p_w),
        .syn_n    (syn_n_w),
        .par_q    (par_reg),
        .npar_q   (npar_reg)
    );

    nand_ecc_syn u_syn (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ecc_clr),
        .restart   (restart_w),
        .code_en   (code_w),
        .slot      (slot_w),
        .wide      (wide_bus),
        .din       (dat_word),
        .check_now (check_w),
        .par_q     (par_reg),
        .npar_q    (npar_reg),
        .syn_p     (syn_p_w),
        .syn_n     (syn_n_w),
        .status_q  (status_w)
    );

    // Drive the flag outputs from the registered status
    always_comb begin
        err_recov   = status_w.recov;
        err_in_code = status_w.in_code;
        err_multi   = status_w.multi;
    end
endmodule

// File: rtl/nand_ecc_engine_chk.sv
// Property checker for the NAND page ECC engine, bound to the top module.
module nand_ecc_engine_chk
    import nand_ecc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ecc_clr,
    input logic             dat_stb,
    input phase_e           phase,
    input logic [LOC_W-1:0] par_reg,
    input logic [LOC_W-1:0] npar_reg,
    input logic             err_recov,
    input logic             err_in_code,
    input logic             err_multi
);
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (par_reg == '0 && npar_reg == '0 && !err_recov && !err_in_code && !err_multi));

    assert_clr_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_clr |=> (par_reg == '0 && npar_reg == '0 && !err_recov && !err_in_code && !err_multi));

    assert_hold_in_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CODE && !ecc_clr) |=> ($stable(par_reg) && $stable(npar_reg)));

    assert_flags_at_check_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_recov) |-> $past(phase == PH_CHECK));

    assert_data_loc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_recov && !err_in_code && !err_multi) |-> ((par_reg ^ npar_reg) == '1));

    assert_code_onebit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_in_code |-> (err_recov && $countones({par_reg, npar_reg}) == 1));

    assert_multi_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_multi |-> (err_recov && !err_in_code));

    assert_new_page_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE && dat_stb && !ecc_clr) |=> (!err_recov && phase == PH_DATA));
endmodule

bind nand_ecc_engine nand_ecc_engine_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ecc_clr     (ecc_clr),
    .dat_stb     (dat_stb),
    .phase       (phase_w),
    .par_reg     (par_reg),
    .npar_reg    (npar_reg),
    .err_recov   (err_recov),
    .err_in_code (err_in_code),
    .err_multi   (err_multi)
);

// File: tb/nand_ecc_engine_bench.sv
module nand_ecc_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ecc_clr = 1'b0;
    logic [1:0]  page_sel = 2'd0;
    logic        wide_bus = 1'b0;
    logic        dat_stb = 1'b0;
    logic [15:0] dat_word = 16'h0;
    logic [15:0] par_reg, npar_reg;
    logic        err_recov, err_in_code, err_multi;

    int total = 0;
    int bad = 0;
    logic [15:0] pg [0:4223];

    always #5 clk = ~clk;

    nand_ecc_engine u_nand_ecc_engine (
        .clk(clk), .rst_n(rst_n), .ecc_clr(ecc_clr), .page_sel(page_sel),
        .wide_bus(wide_bus), .dat_stb(dat_stb), .dat_word(dat_word),
        .par_reg(par_reg), .npar_reg(npar_reg), .err_recov(err_recov),
        .err_in_code(err_in_code), .err_multi(err_multi)
    );

    // kind: 0 clean, 1 data flip, 2 code flip, 3 two data flips
    localparam int NV = 11;
    localparam int V_WIDE [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 0, 1, 1};
    localparam int V_SEL  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 3};
    localparam int V_KIND [NV] = '{0, 1, 1, 2, 2, 3, 1, 2, 1, 0, 1};
    localparam int V_W    [NV] = '{0, 0, 527, 1, 3, 100, 263, 2, 1000, 0, 2111};
    localparam int V_B    [NV] = '{0, 0, 7, 6, 0, 3, 15, 4, 2, 0, 9};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic string kind_tag(input int k);
        case (k)
            0: return "R4/R5";
            1: return "R6";
            2: return "R7";
            3: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Reference parity straight from the bit-address definition
    function automatic void page_par(input int n, input bit wide,
                                     output logic [15:0] p, output logic [15:0] np);
        logic [15:0] a;
        p = 16'h0;
        np = 16'h0;
        for (int i = 0; i < n; i++) begin
            for (int j = 0; j < (wide ? 16 : 8); j++) begin
                if (pg[i][j]) begin
                    a = {i[11:0], j[3:0]};
                    p = p ^ a;
                    np = np ^ ~a;
                end
            end
        end
    endfunction

    task automatic pulse_clr();
        @(negedge clk) ecc_clr = 1'b1;
        @(negedge clk) ecc_clr = 1'b0;
    endtask

    task automatic send(input logic [15:0] w);
        @(negedge clk);
        dat_stb = 1'b1;
        dat_word = w;
    endtask

    task automatic idle();
        @(negedge clk) dat_stb = 1'b0;
    endtask

    task automatic run_page(input bit wide, input logic [1:0] sel, input int kind,
                            input int w, input int b, input int seed,
                            input bit do_clr, input string tag);
        logic [15:0] cp, cn, fp, fn, p0, n0;
        logic [31:0] x;
        logic [7:0]  cb [4];
        logic [2:0]  ef;
        int n;
        n = (528 << sel) >> wide;
        wide_bus = wide;
        page_sel = sel;
        x = seed;
        for (int i = 0; i < n; i++) begin
            x = x * 32'd1664525 + 32'd1013904223;
            if (kind == 4)  pg[i] = wide ? 16'hFFFF : 16'h00FF;
            else if (wide) pg[i] = x[23:8];
            else           pg[i] = {8'h0, x[23:16]};
        end
        page_par(n, wide, cp, cn);
        cb[0] = cp[7:0]; cb[1] = cp[15:8]; cb[2] = cn[7:0]; cb[3] = cn[15:8];
        if (kind == 4) for (int k = 0; k < 4; k++) cb[k] = 8'hFF;
        if (kind == 1 || kind == 3) pg[w][b] = ~pg[w][b];
        if (kind == 3) pg[w+1][b] = ~pg[w+1][b];
        if (kind == 2) cb[w][b] = ~cb[w][b];
        page_par(n, wide, fp, fn);
        page_par(1, wide, p0, n0);
        if (do_clr) pulse_clr();
        for (int i = 0; i < n; i++) begin
            send(pg[i]);
            if (i == 0 && !do_clr) begin
                idle();
                check({"R11 flags after first word ", tag},
                      {29'h0, err_recov, err_in_code, err_multi}, 32'h0);
                check({"R11 parity of word 0 ", tag}, {par_reg, npar_reg}, {p0, n0});
            end
        end
        idle();
        check({"R3 parity after data ", tag}, {16'h0, par_reg}, {16'h0, fp});
        check({"R3 complemented parity ", tag}, {16'h0, npar_reg}, {16'h0, fn});
        if (wide) begin
            send({cb[1], cb[0]});
            send({cb[3], cb[2]});
        end else begin
            for (int k = 0; k < 4; k++) send({8'h0, cb[k]});
        end
        idle();
        @(negedge clk);
        case (kind)
            0: ef = 3'b000;
            1: ef = 3'b100;
            2: ef = 3'b110;
            default: ef = 3'b101;
        endcase
        check({kind_tag(kind), " flags ", tag},
              {29'h0, err_recov, err_in_code, err_multi}, {29'h0, ef});
        check({"R5 syndrome ", tag}, {par_reg, npar_reg},
              {fp ^ {cb[1], cb[0]}, fn ^ {cb[3], cb[2]}});
        if (kind == 1)
            check({"R6 location ", tag}, {16'h0, par_reg}, {16'h0, w[11:0], b[3:0]});
        if (kind == 4)
            check({"R9 erased location ", tag}, {16'h0, par_reg}, 32'h0000FFFF);
    endtask

    initial begin
        #(200000 * 10);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", {par_reg, npar_reg}, 32'h0);
        check("R1 reset flags", {29'h0, err_recov, err_in_code, err_multi}, 32'h0);
        rst_n = 1'b1;

        // table walk: R2 sizes, R12 wide mode, R5..R8 outcomes
        for (int v = 0; v < NV; v++) begin
            run_page(V_WIDE[v] != 0, 2'(V_SEL[v]), V_KIND[v], V_W[v], V_B[v], v + 1, 1'b1,
                     $sformatf("R2/R12 vec%0d", v));
        end

        // R9: erased page in both widths
        run_page(1'b0, 2'd0, 4, 0, 0, 50, 1'b1, "R9 byte");
        run_page(1'b1, 2'd0, 4, 0, 0, 51, 1'b1, "R9 wide");

        // R10: clear after a flagged page, then junk words before a clear
        run_page(1'b0, 2'd0, 3, 10, 1, 60, 1'b1, "R8 pre-clear");
        pulse_clr();
        check("R10 clear flags", {29'h0, err_recov, err_in_code, err_multi}, 32'h0);
        check("R10 clear parity", {par_reg, npar_reg}, 32'h0);
        send(16'h00A5);
        send(16'h003C);
        send(16'h0081);
        idle();
        run_page(1'b0, 2'd0, 0, 0, 0, 61, 1'b1, "R10 junk dropped");

        // R11: flagged page, then a new page with no clear
        run_page(1'b0, 2'd0, 1, 5, 5, 70, 1'b1, "R11 first");
        run_page(1'b0, 2'd0, 0, 0, 0, 71, 1'b0, "R11 second");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule